// File: doc/BRIEF.md
# GHASH Streaming Accumulator with Key Setup

This block computes the GCM authentication hash over a byte stream of any length. A 16-byte hash key is loaded once through the key port. The block stores it in a pre-scaled form: the key divided by x in the field, which in the byte-swapped representation is a one-bit left shift with a conditional fold of the reduction constant. Message bytes then enter one per accepted handshake. Each byte is XORed in place into a 16-byte accumulator at the next free position. After the sixteenth byte of a block the accumulator is multiplied by the key in GF(2^128).

A finalize command, either a separate pulse or the last flag on a byte, closes the stream. A trailing partial block is treated as zero-padded and costs exactly one more multiply. When nothing is pending, no multiply is run. The 16-byte result is then flagged for one cycle and held until the next init.

All 128-bit buses carry byte 0 of the key, block or digest in bits [127:120], with byte k at [127-8k -: 8]. This is the byte-swapped domain in which the field arithmetic is done. The multiplier is a digit-serial submodule that retires STEP_BITS key-weighted steps per cycle.

Top module: `ghash_stream`

## Requirements
- R1: A key load with key_len equal to 16 stores the key so that every later digest equals GHASH with that key (byte 0 in bits [127:120]), including keys with bit 127 or bit 63 set.
- R2: A key load with key_len other than 16 sets key_err one cycle later and leaves the stored key unchanged; an accepted load clears key_err.
- R3: init clears the accumulator and the byte count and abandons any multiply in progress, so that a following finalize with no bytes gives an all-zero digest.
- R4: The byte accepted at position k of a block (k counted from 0 since the last block boundary) is XORed into accumulator bits [127-8k -: 8], and the count advances by one.
- R5: Accepting the 16th byte of a block starts one multiply of the updated accumulator by the key; in_ready stays low while the multiply runs.
- R6: A byte is absorbed only on a cycle with in_valid and in_ready both high; bytes presented while in_valid is low or in_ready is low have no effect on the digest.
- R7: On finalize with 1 to 15 pending bytes, the block is zero-padded and multiplied once before the digest is flagged.
- R8: On finalize with no pending bytes and no multiply running, no multiply is started and dig_valid rises on the second clock edge after the finalize pulse.
- R9: A finalize that arrives while a multiply runs is held, takes effect after that multiply completes, and does not flag the digest on the next cycle.
- R10: dig_valid is high for exactly one cycle; afterwards digest is held and in_ready stays low until the next init.
- R11: in_last on an accepted byte finalizes the stream after that byte, exactly as a finalize pulse would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_load | input | 1 | Load key_bytes as the hash key this cycle |
| key_len | input | LEN_W | Byte length claimed for the key; only 16 is accepted |
| key_bytes | input | 128 | Key, byte 0 in [127:120] |
| key_err | output | 1 | Last key load was rejected |
| init | input | 1 | Start a new message: clear accumulator and count |
| in_valid | input | 1 | in_byte holds a message byte |
| in_byte | input | 8 | Message byte |
| in_last | input | 1 | This byte is the final one of the message |
| in_ready | output | 1 | Block can take a byte this cycle |
| fin_req | input | 1 | Finalize the message |
| dig_valid | output | 1 | One-cycle flag: digest is ready |
| digest | output | 128 | Hash result, byte 0 in [127:120] |

## Verification
The bench sweeps every message length from 0 to 40 bytes under three keys. One key has bit 127 set, so the shifted-out bit triggers the fold, and one has bit 63 set, so the cross-lane carry matters. Each digest is compared with a textbook bit-serial GF(2^128) model, and a published GCM vector is checked as well. A wrong fold constant or carry corrupts every digest for the affected keys. Off-by-one block counting shows at lengths 15, 16, 17, 31 and 32. Stalls and invalid junk bytes between accepted bytes catch a design that absorbs without the handshake. The bench also times finalize on empty and full-block boundaries to catch a spurious extra multiply. It aborts a message mid-multiply with init and retries a rejected key length, which exposes stale accumulators and key overwrites.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

  localparam int unsigned GH_BITS  = 128;
  localparam int unsigned GH_BYTES = GH_BITS / 8;
  localparam int unsigned GH_CNT_W = $clog2(GH_BYTES);

  // Fold applied when the key's shifted-out bit (coefficient of x^0) was one.
  localparam logic [GH_BITS-1:0] GH_FOLD_DIV = 128'hC2000000000000000000000000000001;
  // Fold applied when multiplying by x pushes out the x^127 coefficient.
  localparam logic [GH_BITS-1:0] GH_FOLD_MUL = {8'hE1, 120'd0};

  typedef logic [GH_BITS-1:0] gh_word_t;

  typedef enum logic [1:0] {
    PH_ABSORB = 2'd0,
    PH_FLUSH  = 2'd1,
    PH_DONE   = 2'd2
  } gh_phase_t;

  // Pre-scale the key: shift the byte-swapped word up one bit (the 64-bit
  // lane boundary carries naturally) and fold when the top bit falls out.
  function automatic gh_word_t gh_key_prescale(input gh_word_t k);
    gh_word_t s;
    s = {k[GH_BITS-2:0], 1'b0};
    if (k[GH_BITS-1]) s = s ^ GH_FOLD_DIV;
    return s;
  endfunction

  // Multiply a byte-swapped field element by x.
  function automatic gh_word_t gh_times_x(input gh_word_t v);
    gh_word_t r;
    r = v >> 1;
    if (v[0]) r = r ^ GH_FOLD_MUL;
    return r;
  endfunction

  // One Horner step: z*x plus v when the operand bit is set.
  function automatic gh_word_t gh_step(input gh_word_t z, input gh_word_t v,
                                       input logic bit_in);
    return gh_times_x(z) ^ (bit_in ? v : '0);
  endfunction

  // Position a byte at slot idx of a block (slot 0 in the top byte).
  function automatic gh_word_t gh_place_byte(input logic [7:0] b,
                                             input logic [GH_CNT_W-1:0] idx);
    return {b, 120'd0} >> {idx, 3'b000};
  endfunction

endpackage

// File: rtl/ghash_key_store.sv
module ghash_key_store
  import ghash_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  gh_word_t         key_in,
  output gh_word_t         hkey,
  output logic             err
);

  localparam logic [LEN_W-1:0] GOOD_LEN = LEN_W'(GH_BYTES);

  logic len_ok;
  assign len_ok = (len == GOOD_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hkey <= '0;
      err  <= 1'b0;
    end else if (load) begin
      err <= !len_ok;
      if (len_ok) hkey <= gh_key_prescale(key_in);
    end
  end

endmodule

// File: rtl/ghash_digit_mul.sv
module ghash_digit_mul
  import ghash_pkg::*;
#(
  parameter int unsigned STEP_BITS = 8   // must divide 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     abort,
  input  logic     start,
  input  gh_word_t op_a,
  input  gh_word_t op_hs,   // pre-scaled key (key / x)
  output logic     busy,
  output logic     done,
  output gh_word_t result
);

  localparam int unsigned ROUNDS = GH_BITS / STEP_BITS;
  localparam int unsigned RW     = $clog2(ROUNDS + 1);
  localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS - 1);

  gh_word_t      z_q, v_q, a_sr, z_nx;
  logic [RW-1:0] rnd_q;
  logic          busy_q, done_q;

  // Operand bits are consumed from bit 0 (coefficient of x^127) upward.
  always_comb begin
    z_nx = z_q;
    for (int s = 0; s < STEP_BITS; s++) begin
      z_nx = gh_step(z_nx, v_q, a_sr[s]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q    <= '0;
      v_q    <= '0;
      a_sr   <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
      end else if (start) begin
        z_q    <= '0;
        v_q    <= gh_times_x(op_hs);   // undo the pre-scale: back to key
        a_sr   <= op_a;
        rnd_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        z_q  <= z_nx;
        a_sr <= a_sr >> STEP_BITS;
        if (rnd_q == LAST_RND) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rnd_q <= rnd_q + RW'(1);
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = z_q;

endmodule

// File: rtl/ghash_stream.sv
module ghash_stream
  import ghash_pkg::*;
#(
  parameter int unsigned STEP_BITS = 8,
  parameter int unsigned LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [LEN_W-1:0] key_len,
  input  logic [127:0]     key_bytes,
  output logic             key_err,
  input  logic             init,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             fin_req,
  output logic             dig_valid,
  output logic [127:0]     digest
);

  localparam logic [GH_CNT_W-1:0] LAST_SLOT = GH_CNT_W'(GH_BYTES - 1);

  gh_word_t            acc_q, acc_upd, hkey, mul_op_a, mul_result;
  logic [GH_CNT_W-1:0] cnt_q;
  logic                fin_pend_q, dig_valid_q;
  gh_phase_t           phase_q;
  logic                mul_busy, mul_done, mul_active;

  // Named events, also observed by the checker.
  logic ev_accept, ev_block_full, ev_flush, ev_close, ev_mul_start;
  logic done_phase, absorb_phase;

  ghash_key_store #(.LEN_W(LEN_W)) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (key_load),
    .len    (key_len),
    .key_in (key_bytes),
    .hkey   (hkey),
    .err    (key_err)
  );

  assign absorb_phase  = (phase_q == PH_ABSORB);
  assign done_phase    = (phase_q == PH_DONE);
  assign mul_active    = mul_busy | mul_done;
  assign in_ready      = absorb_phase && !mul_active && !fin_pend_q;
  assign ev_accept     = in_valid && in_ready && !init;
  assign acc_upd       = acc_q ^ gh_place_byte(in_byte, cnt_q);
  assign ev_block_full = ev_accept && (cnt_q == LAST_SLOT);

  // Finalize resolves only once no multiply is in flight.
  assign ev_flush = absorb_phase && fin_pend_q && !mul_active && !init && (cnt_q != '0);
  assign ev_close = absorb_phase && fin_pend_q && !mul_active && !init && (cnt_q == '0);

  assign ev_mul_start = ev_block_full || ev_flush;
  assign mul_op_a     = ev_flush ? acc_q : acc_upd;  // padding XORs zero: no change

  ghash_digit_mul #(.STEP_BITS(STEP_BITS)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (init),
    .start  (ev_mul_start),
    .op_a   (mul_op_a),
    .op_hs  (hkey),
    .busy   (mul_busy),
    .done   (mul_done),
    .result (mul_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      fin_pend_q  <= 1'b0;
      dig_valid_q <= 1'b0;
      phase_q     <= PH_ABSORB;
    end else begin
      dig_valid_q <= 1'b0;
      if (init) begin
        acc_q      <= '0;
        cnt_q      <= '0;
        fin_pend_q <= 1'b0;
        phase_q    <= PH_ABSORB;
      end else begin
        if (ev_accept) begin
          acc_q <= acc_upd;
          cnt_q <= cnt_q + GH_CNT_W'(1);
          if (in_last) fin_pend_q <= 1'b1;
        end
        if (fin_req && absorb_phase) fin_pend_q <= 1'b1;
        if (mul_done) acc_q <= mul_result;
        if (ev_flush) begin
          cnt_q   <= '0;
          phase_q <= PH_FLUSH;
        end
        if ((phase_q == PH_FLUSH) && mul_done) begin
          phase_q     <= PH_DONE;
          dig_valid_q <= 1'b1;
          fin_pend_q  <= 1'b0;
        end
        if (ev_close) begin
          phase_q     <= PH_DONE;
          dig_valid_q <= 1'b1;
          fin_pend_q  <= 1'b0;
        end
      end
    end
  end

  assign dig_valid = dig_valid_q;
  assign digest    = acc_q;

endmodule

// File: rtl/ghash_stream_chk.sv
module ghash_stream_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             key_load,
  input logic [LEN_W-1:0] key_len,
  input logic [127:0]     hkey,
  input logic             key_err,
  input logic             in_ready,
  input logic             ev_accept,
  input logic [3:0]       cnt_q,
  input logic [127:0]     acc_q,
  input logic             mul_busy,
  input logic             ev_mul_start,
  input logic             fin_req,
  input logic             dig_valid,
  input logic             done_phase,
  input logic [127:0]     digest
);

  localparam logic [LEN_W-1:0] KEY_BYTES = LEN_W'(16);

  // R2
  bad_key_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_load && (key_len != KEY_BYTES) |=> key_err && (hkey == $past(hkey)));

  // R2
  good_key_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_load && (key_len == KEY_BYTES) |=> !key_err);

  // R3
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (acc_q == '0) && (cnt_q == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && (cnt_q != 4'd15) |=> cnt_q == $past(cnt_q) + 4'd1);

  // R5
  full_block_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && (cnt_q == 4'd15) |-> ev_mul_start);

  // R5
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_busy |-> !in_ready);

  // R9
  fin_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_req && mul_busy |=> !dig_valid);

  // R10
  dig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |=> !dig_valid);

  // R10
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_phase && !init |=> $stable(digest) && !in_ready);

endmodule

bind ghash_stream ghash_stream_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init         (init),
  .key_load     (key_load),
  .key_len      (key_len),
  .hkey         (hkey),
  .key_err      (key_err),
  .in_ready     (in_ready),
  .ev_accept    (ev_accept),
  .cnt_q        (cnt_q),
  .acc_q        (acc_q),
  .mul_busy     (mul_busy),
  .ev_mul_start (ev_mul_start),
  .fin_req      (fin_req),
  .dig_valid    (dig_valid),
  .done_phase   (done_phase),
  .digest       (digest)
);

// File: tb/sim_ghash_stream.sv
module sim_ghash_stream;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [7:0]   key_len = 8'd0;
  logic [127:0] key_bytes = '0;
  logic         key_err;
  logic         init = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_byte = 8'h00;
  logic         in_last = 1'b0;
  logic         in_ready;
  logic         fin_req = 1'b0;
  logic         dig_valid;
  logic [127:0] digest;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [7:0] msg [0:63];

  localparam logic [127:0] KEY_A = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
  localparam logic [127:0] KEY_B = 128'h80000000000000008000000000000000;
  localparam logic [127:0] KEY_C = 128'hb83b533708bf535d0aa6e52980d53b78;

  always #10 clk = ~clk;  // 50 MHz

  ghash_stream u0 (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_len(key_len),
    .key_bytes(key_bytes), .key_err(key_err), .init(init),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .in_ready(in_ready), .fin_req(fin_req), .dig_valid(dig_valid),
    .digest(digest)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Textbook GCM multiply: MSB-first operand scan, right-shifting V.
  function automatic logic [127:0] ref_mul(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z, v;
    z = '0;
    v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z = z ^ v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'd0}) : (v >> 1);
    end
    return z;
  endfunction

  function automatic logic [127:0] ref_ghash(input logic [127:0] h, input int n);
    logic [127:0] y, blk;
    y = '0;
    for (int b = 0; b < (n + 15) / 16; b++) begin
      blk = '0;
      for (int j = 0; j < 16; j++)
        if (b * 16 + j < n) blk[127-8*j -: 8] = msg[b*16+j];
      y = ref_mul(y ^ blk, h);
    end
    return y;
  endfunction

  task automatic load_key(input logic [127:0] k, input logic [7:0] len);
    key_load = 1'b1; key_bytes = k; key_len = len;
    @(negedge clk);
    key_load = 1'b0; key_bytes = 128'hdead; key_len = 8'd0;
  endtask

  task automatic pulse_init();
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic pulse_fin();
    fin_req = 1'b1;
    @(negedge clk);
    fin_req = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic last);
    in_valid = 1'b1; in_byte = b; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_byte = 8'hC3;
  endtask

  task automatic fill_msg(input int n, input int seed);
    for (int i = 0; i < 64; i++) msg[i] = 8'((i * 37) + (n * 11) + seed);
  endtask

  // mode 0: finalize pulse; 1: in_last on the final byte; 2: pulse with idle junk gaps
  task automatic run_msg(input logic [127:0] h, input int n, input int mode, input string tag);
    logic [127:0] d;
    int lat;
    pulse_init();
    for (int i = 0; i < n; i++) begin
      push(msg[i], (mode == 1) && (i == n - 1));
      if (mode == 2) begin
        in_byte = 8'h5A;  // R6: present but not valid
        @(negedge clk);
      end
    end
    if (!(mode == 1 && n > 0)) pulse_fin();
    lat = 0;
    while (!dig_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk128(tag, digest, ref_ghash(h, n));
    if (n == 0 && mode != 1) chk_int("R8 latency", lat, 1);
    if ((n % 16) != 0 && mode != 1) chk_int("R7 multiply ran", int'(lat > 1), 1);
    d = digest;
    @(negedge clk);
    chk_int("R10 pulse", int'(dig_valid), 0);
    chk128("R10 hold", digest, d);
    chk_int("R10 ready low", int'(in_ready), 0);
  endtask

  initial begin
    logic [127:0] tv_c;
    logic [127:0] held;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk_int("R10 reset dig_valid", int'(dig_valid), 0);
    chk_int("R2 reset key_err", int'(key_err), 0);
    chk_int("R6 reset ready", int'(in_ready), 1);
    chk128("R3 reset digest", digest, '0);

    // Published GCM vector: one ciphertext block plus the length block.
    load_key(KEY_A, 8'd16);
    chk_int("R1 key accepted", int'(key_err), 0);
    tv_c = 128'h0388dace60b6a392f328c2b971b2fe78;
    for (int i = 0; i < 16; i++) msg[i] = tv_c[127-8*i -: 8];
    for (int i = 16; i < 32; i++) msg[i] = 8'h00;
    msg[31] = 8'h80;
    run_msg(KEY_A, 32, 0, "R5 vector");
    chk128("R1 vector value", digest, 128'hf38cbb1ad69223dcc3457ae5b6b0f885);

    // Length sweep under three keys (R1, R4, R5, R7, R8, R9, R11).
    for (int k = 0; k < 3; k++) begin
      logic [127:0] kk;
      kk = (k == 0) ? KEY_A : (k == 1) ? KEY_B : KEY_C;
      load_key(kk, 8'd16);
      for (int n = 0; n <= 40; n++) begin
        int mode;
        mode = (n + k) % 3;
        fill_msg(n, k * 5);
        if (mode == 1 && n > 0) tag = "R11 in_last";
        else if (n == 0) tag = "R8 empty";
        else if ((n % 16) == 0) tag = "R9 full block";
        else tag = "R4 R7 partial";
        run_msg(kk, n, mode, tag);
      end
    end

    // R2: rejected lengths leave the key alone.
    load_key(KEY_A, 8'd16);
    load_key(KEY_B, 8'd15);
    chk_int("R2 err set len15", int'(key_err), 1);
    load_key(KEY_C, 8'd17);
    chk_int("R2 err set len17", int'(key_err), 1);
    load_key(KEY_B, 8'd0);
    chk_int("R2 err set len0", int'(key_err), 1);
    fill_msg(20, 3);
    run_msg(KEY_A, 20, 0, "R2 key unchanged");
    load_key(KEY_B, 8'd16);
    chk_int("R2 err cleared", int'(key_err), 0);
    run_msg(KEY_B, 20, 0, "R1 new key");

    // R3: init mid-block, and init while a multiply runs.
    pulse_init();
    for (int i = 0; i < 5; i++) push(8'hF0 + 8'(i), 1'b0);
    fill_msg(9, 7);
    run_msg(KEY_B, 9, 0, "R3 init mid block");
    pulse_init();
    for (int i = 0; i < 16; i++) push(8'(i * 3 + 1), 1'b0);
    pulse_init();
    pulse_fin();
    while (!dig_valid) @(negedge clk);
    chk128("R3 init during multiply", digest, '0);

    // R10: after the digest, finalize and bytes are ignored until init.
    held = digest;
    pulse_fin();
    in_valid = 1'b1; in_byte = 8'h77;
    repeat (4) begin
      @(negedge clk);
      chk_int("R10 no second pulse", int'(dig_valid), 0);
    end
    in_valid = 1'b0;
    chk128("R10 digest held", digest, held);

    summary();
    $finish;
  end

endmodule